// File: doc/BRIEF.md
# Slow-Clock System Timer

This peripheral runs three timers from one 32768 Hz slow clock and exposes them through a small 32-bit register bus. The first is an interval timer that raises a tick flag every programmed number of slow-clock periods. The second is a free-running real-time counter behind a programmable prescaler, used as a timebase. The third is a watchdog that can issue a system reset pulse when software fails to restart it in time.

The slow clock is asynchronous to the bus clock. It is passed through a synchronizer, and its rising edge becomes a one-cycle tick in the bus domain. All counters and registers then live in the bus clock domain. Because of this, a read of the real-time counter is always coherent. The three event flags feed one interrupt line. That line is the OR of the flags that are enabled, so software that shares the line can read the status register to see whether the interrupt is its own.

Top module: `slow_sys_timer`

## Requirements
- R1: After reset, every register reads 0, except the prescaler register at 0x0C, which reads 0x00008000. `irq` and `wd_reset` are low.
- R2: Register map (byte offsets):
  - 0x00 command, write only. Bit 0 restarts the watchdog.
  - 0x04 interval reload, bits 15:0.
  - 0x08 watchdog mode. Bits 15:0 are the reload and bit 16 is reset-enable.
  - 0x0C prescaler reload, bits 15:0.
  - 0x10 status. Bit 0 is interval expiry, bit 1 is watchdog expiry and bit 2 is real-time counter step.
  - 0x14 enable-set, write only.
  - 0x18 enable-clear, write only.
  - 0x1C enable mask, read only.
  - 0x20 real-time counter value.
  - The read/write registers read back what was written.
- R3: With interval reload N > 0, status bit 0 sets once every N slow ticks, counted from the write of the reload. A reload of 0 stops the interval timer.
- R4: The real-time counter advances by one, and sets status bit 2, once every P slow ticks, where P is the prescaler reload. P = 0 and P = 1 both advance it on every tick. Writing the prescaler register clears the counter and restarts the prescale count.
- R5: The real-time counter wraps modulo 2^RTC_W (RTC_W = 20 by default).
- R6: A 1 written to the enable-set register sets the matching mask bit. A 1 written to the enable-clear register clears it. Zero bits leave the mask unchanged, and writing all ones to enable-clear masks every source.
- R7: `irq` is high exactly when some status bit and its mask bit are both set.
- R8: A read of the status register returns the flags and clears bits 0 to 2. An event in the same cycle wins over the clear.
- R9: A watchdog restart loads reload×64 slow ticks; a write to the watchdog mode register also restarts it. When the count runs out, status bit 1 sets. `wd_reset` pulses only if reset-enable is set. With reload 2, the expiry comes 128 ticks after the restart.
- R10: With a watchdog reload of 0, the watchdog never expires.
- R11: Two back-to-back reads of the real-time counter with no slow tick between them return the same value.
- R12: A `wd_reset` pulse lasts exactly one bus clock, and one is issued per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | 32768 Hz slow clock, asynchronous |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| irq | output | 1 | Shared interrupt, OR of enabled status flags |
| wd_reset | output | 1 | One-cycle watchdog reset pulse |

## Verification
The checks assume the following about the inputs:
- The slow clock stays high and then low for at least three bus clocks each, so that the synchronizer produces exactly one tick per slow period.
- Each bus access lasts a single cycle.

The check on clear-on-read is guarded against a tick that lands in the same cycle as the read, because a new event may then set a flag again. The bench holds each slow-clock phase for four bus clocks. It issues bus accesses only between tick windows, so a write or a read never coincides with a counter update.

// File: rtl/slow_sys_timer.sv
`timescale 1ns/1ps
module slow_sys_timer #(
  parameter int ADDR_W   = 8,
  parameter int RLD_W    = 16,
  parameter int RTC_W    = 20,
  parameter int WD_SHIFT = 6,
  parameter int PRE_RST  = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wd_reset
);
  localparam int WD_W = RLD_W + WD_SHIFT;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PIV  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_WDM  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RTP  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_IDIS = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_RTV  = ADDR_W'(8'h20);

  logic [2:0] sync;
  logic       tick;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], slow_clk};
  assign tick = sync[1] & ~sync[2];

  logic wr, rd;
  assign wr = bus_sel & bus_wr;
  assign rd = bus_sel & ~bus_wr;

  logic wr_cmd, wr_piv, wr_wdm, wr_rtp, wr_ien, wr_idis, rd_sts;
  assign wr_cmd  = wr && bus_addr == A_CMD;
  assign wr_piv  = wr && bus_addr == A_PIV;
  assign wr_wdm  = wr && bus_addr == A_WDM;
  assign wr_rtp  = wr && bus_addr == A_RTP;
  assign wr_ien  = wr && bus_addr == A_IEN;
  assign wr_idis = wr && bus_addr == A_IDIS;
  assign rd_sts  = rd && bus_addr == A_STS;

  logic [RLD_W-1:0] piv_rld, piv_cnt;
  logic             pit_hit;
  assign pit_hit = tick && !wr_piv && piv_rld != '0 && piv_cnt <= RLD_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      piv_rld <= '0;
      piv_cnt <= '0;
    end else if (wr_piv) begin
      piv_rld <= bus_wdata[RLD_W-1:0];
      piv_cnt <= bus_wdata[RLD_W-1:0];
    end else if (tick && piv_rld != '0) begin
      piv_cnt <= pit_hit ? piv_rld : piv_cnt - 1'b1;
    end

  logic [RLD_W-1:0] rtp_rld, pre_cnt;
  logic [RTC_W-1:0] rtv;
  logic             rt_hit;
  assign rt_hit = tick && !wr_rtp && pre_cnt <= RLD_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rtp_rld <= RLD_W'(PRE_RST);
      pre_cnt <= RLD_W'(PRE_RST);
      rtv     <= '0;
    end else if (wr_rtp) begin
      rtp_rld <= bus_wdata[RLD_W-1:0];
      pre_cnt <= bus_wdata[RLD_W-1:0];
      rtv     <= '0;
    end else if (tick) begin
      pre_cnt <= rt_hit ? rtp_rld : pre_cnt - 1'b1;
      if (rt_hit) rtv <= rtv + 1'b1;
    end

  logic [RLD_W-1:0] wd_rld;
  logic             wd_ren;
  logic [WD_W-1:0]  wd_cnt;
  logic             restart, wd_hit;
  assign restart = wr_cmd && bus_wdata[0];
  assign wd_hit  = tick && !restart && !wr_wdm && wd_cnt == WD_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_rld   <= '0;
      wd_ren   <= 1'b0;
      wd_cnt   <= '0;
      wd_reset <= 1'b0;
    end else begin
      wd_reset <= wd_hit & wd_ren;
      if (wr_wdm) begin
        wd_rld <= bus_wdata[RLD_W-1:0];
        wd_ren <= bus_wdata[RLD_W];
        wd_cnt <= {bus_wdata[RLD_W-1:0], {WD_SHIFT{1'b0}}};
      end else if (restart) begin
        wd_cnt <= {wd_rld, {WD_SHIFT{1'b0}}};
      end else if (tick && wd_cnt != '0) begin
        wd_cnt <= wd_cnt - 1'b1;
      end
    end

  logic [2:0] sts, imask;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts   <= '0;
      imask <= '0;
    end else begin
      sts <= (rd_sts ? 3'b000 : sts) | {rt_hit, wd_hit, pit_hit};
      if (wr_ien)  imask <= imask | bus_wdata[2:0];
      if (wr_idis) imask <= imask & ~bus_wdata[2:0];
    end

  assign irq = |(sts & imask);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PIV:  bus_rdata[RLD_W-1:0] = piv_rld;
      A_WDM:  bus_rdata[RLD_W:0]   = {wd_ren, wd_rld};
      A_RTP:  bus_rdata[RLD_W-1:0] = rtp_rld;
      A_STS:  bus_rdata[2:0]       = sts;
      A_MASK: bus_rdata[2:0]       = imask;
      A_RTV:  bus_rdata[RTC_W-1:0] = rtv;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/slow_sys_timer_chk.sv
`timescale 1ns/1ps
module slow_sys_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int RLD_W  = 16,
  parameter int RTC_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              wd_reset,
  input logic              tick,
  input logic [2:0]        sts,
  input logic [2:0]        imask,
  input logic              wd_ren,
  input logic [RTC_W-1:0]  rtv,
  input logic [RLD_W-1:0]  piv_cnt,
  input logic [RLD_W-1:0]  piv_rld
);
  // R12
  wd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);
  // R9
  wd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> (wd_ren && sts[1]));
  // R6
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(8'h18) && bus_wdata[2:0] == 3'b111) |=> !irq);
  // R8
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h10) && !tick) |=> sts == 3'b000);
  // R4
  rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'(8'h0C)) |=>
      (rtv == $past(rtv) || rtv == RTC_W'($past(rtv) + 1'b1)));
  // R3
  piv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    piv_cnt <= piv_rld);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imask != 3'b000 && sts != 3'b000));
endmodule

bind slow_sys_timer slow_sys_timer_chk #(.ADDR_W(ADDR_W), .RLD_W(RLD_W), .RTC_W(RTC_W)) chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .wd_reset(wd_reset), .tick(tick), .sts(sts),
  .imask(imask), .wd_ren(wd_ren), .rtv(rtv), .piv_cnt(piv_cnt), .piv_rld(piv_rld));

// File: tb/slow_sys_timer_test.sv
`timescale 1ns/1ps
module slow_sys_timer_test;
  localparam int RTC_W = 8;
  logic clk = 0, rst_n = 0, slow_clk = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, wd_reset;
  int checks = 0, errors = 0, pulses = 0, hi_cyc = 0;
  logic prev_rst = 0;
  bit done = 0;

  slow_sys_timer #(.RTC_W(RTC_W)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wd_reset(wd_reset));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (wd_reset) hi_cyc++;
    if (wd_reset && !prev_rst) pulses++;
    prev_rst <= wd_reset;
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_clk = 1;
      repeat (4) @(negedge clk);
      slow_clk = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  // {interval reload, slow ticks, expected status bit 0}
  localparam logic [23:0] PIT_VEC [6] = '{
    {16'd3, 7'd2, 1'b0}, {16'd3, 7'd3, 1'b1}, {16'd1, 7'd1, 1'b1},
    {16'd5, 7'd4, 1'b0}, {16'd5, 7'd7, 1'b1}, {16'd0, 7'd9, 1'b0}};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h10, v); check("R1 status", v, 0);
    rd(8'h1C, v); check("R1 mask", v, 0);
    rd(8'h0C, v); check("R1 prescaler", v, 32'h8000);
    rd(8'h20, v); check("R1 rtc", v, 0);
    rd(8'h04, v); check("R1 interval", v, 0);
    rd(8'h08, v); check("R1 wdmode", v, 0);
    check("R1 irq", irq, 0);
    check("R1 wd_reset", wd_reset, 0);
    // R2 readback
    wr(8'h08, 32'h0001_0005); rd(8'h08, v); check("R2 wdmode", v, 32'h0001_0005);
    wr(8'h08, 0);
    wr(8'h04, 32'h1234); rd(8'h04, v); check("R2 interval", v, 32'h1234);
    wr(8'h0C, 32'hFFFF); rd(8'h0C, v); check("R2 prescaler", v, 32'hFFFF);
    // R3 vector table
    foreach (PIT_VEC[i]) begin
      wr(8'h04, {16'd0, PIT_VEC[i][23:8]});
      rd(8'h10, v);
      ticks(int'(PIT_VEC[i][7:1]));
      rd(8'h10, v);
      check($sformatf("R3 vec%0d", i), v[0], PIT_VEC[i][0]);
    end
    // R4 prescaler
    wr(8'h0C, 3); rd(8'h20, v); check("R4 cleared", v, 0);
    ticks(7); rd(8'h20, v); check("R4 p3", v, 2);
    rd(8'h10, v); check("R4 status bit2", v[2], 1);
    wr(8'h0C, 1); ticks(5); rd(8'h20, v); check("R4 p1", v, 5);
    wr(8'h0C, 0); ticks(2); rd(8'h20, v); check("R4 p0", v, 2);
    // R5 wrap
    wr(8'h0C, 1); ticks(1 << RTC_W); rd(8'h20, v); check("R5 wrap", v, 0);
    ticks(3); rd(8'h20, v); check("R5 after wrap", v, 3);
    // R11 coherent reads
    rd(8'h20, v); rd(8'h20, v2); check("R11 stable", v2, v);
    // R6 R7 masking and interrupt
    wr(8'h0C, 32'hFFFF);
    wr(8'h04, 2); rd(8'h10, v);
    wr(8'h14, 1); rd(8'h1C, v); check("R6 set", v, 1);
    check("R7 no flag", irq, 0);
    ticks(2); check("R7 irq", irq, 1);
    wr(8'h14, 0); rd(8'h1C, v); check("R6 zero write", v, 1);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h1C, v); check("R6 clear all", v, 0);
    check("R7 masked", irq, 0);
    // R8 clear on read
    rd(8'h10, v); check("R8 flag seen", v[0], 1);
    wr(8'h04, 0);
    rd(8'h10, v); check("R8 cleared", v, 0);
    wr(8'h14, 2); rd(8'h1C, v); check("R6 bit1", v, 2);
    wr(8'h18, 2); rd(8'h1C, v); check("R6 bit1 clr", v, 0);
    // R9 watchdog reload 2 with reset enabled
    wr(8'h08, 32'h0001_0002);
    ticks(127); check("R9 early", pulses, 0);
    rd(8'h10, v); check("R9 early status", v[1], 0);
    ticks(1); check("R9 expiry 128", pulses, 1);
    rd(8'h10, v); check("R9 status", v[1], 1);
    ticks(10); check("R9 stopped", pulses, 1);
    wr(8'h00, 1); ticks(100); wr(8'h00, 1); ticks(127);
    check("R9 restart", pulses, 1);
    ticks(1); check("R9 after restart", pulses, 2);
    // R12 pulse width
    check("R12 width", hi_cyc, 2);
    // R10 disabled
    wr(8'h08, 32'h0001_0000); wr(8'h00, 1); rd(8'h10, v);
    ticks(200); check("R10 no reset", pulses, 2);
    rd(8'h10, v); check("R10 no flag", v[1], 0);
    // R9 no reset-enable: flag only
    wr(8'h08, 1); ticks(64);
    check("R9 gated", pulses, 2);
    rd(8'h10, v); check("R9 gated flag", v[1], 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule